// File: doc/BRIEF.md
# Width-Selectable Masked-AND Flag Unit

The unit takes two 64-bit operand buses and a size select for 8, 16, 32 or 64 bits. It forms the bitwise AND of the two operands at that width and derives a set of status flags from the truncated product. In AND mode the product is registered and presented with a write-enable so a register file can store it. In compare mode the product is dropped and only the flags change. An immediate-mode input covers the 64-bit form whose second operand is a 32-bit immediate: that immediate is sign-extended to 64 bits before the AND.

All outputs are registered. They appear one clock after a valid strobe, and a synchronous active-high reset clears them.

Top module: `andflag_unit`

## Requirements
- R1: One cycle after `in_valid`, `res_q` holds (`opa` AND `opb`) truncated to the selected width and zero-extended to 64 bits. The width code `width_sel` is 0=8, 1=16, 2=32 and 3=64 bits.
- R2: When `width_sel`=3 and `imm_mode`=1, bits 63:32 of `opb` are ignored and bit 31 of `opb` is copied into them before the AND. At any narrower width, `imm_mode` has no effect.
- R3: `sign_q` equals the top bit of the truncated product: bit 7, 15, 31 or 63.
- R4: `zero_q` is 1 exactly when the truncated product is zero. Operand bits above the selected width cannot clear it.
- R5: `parity_q` is 1 when bits 7:0 of the product hold an even number of ones, at every width.
- R6: `carry_q`, `ovf_q` and `aux_q` are 0 after every operation.
- R7: `wr_en_q` is 1 one cycle after a valid operation with `cmp_mode`=0. It is 0 in every other cycle.
- R8: With `cmp_mode`=1, `res_q` keeps its previous value. The flags still update and `flags_vld_q` pulses.
- R9: `flags_vld_q` is 1 exactly one cycle after each `in_valid`. Without `in_valid`, all flag and result outputs hold their values.
- R10: Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand or immediate |
| width_sel | input | 2 | Operand width code |
| imm_mode | input | 1 | Second operand is a 32-bit immediate |
| cmp_mode | input | 1 | 1 = compare only, 0 = AND with write-back |
| res_q | output | 64 | Registered product |
| wr_en_q | output | 1 | Write-enable for `res_q` |
| sign_q | output | 1 | Sign flag |
| zero_q | output | 1 | Zero flag |
| parity_q | output | 1 | Even-parity flag of low byte |
| carry_q | output | 1 | Carry flag (always 0) |
| ovf_q | output | 1 | Overflow flag (always 0) |
| aux_q | output | 1 | Auxiliary flag (driven 0) |
| flags_vld_q | output | 1 | Flags updated this cycle |

## Verification
Random operands are applied at every width, in both modes and with and without the immediate form.

Directed cases separate narrow-width truncation from full-width behaviour:
- Operands whose only set bits lie above the selected width must give a zero flag.
- A product whose low byte is zero while upper bits are set shows that parity ignores the upper bits.
- Immediates with bit 31 set and clear show whether sign extension took place, and whether `imm_mode` is wrongly honoured at narrow widths.

Compare runs placed between AND runs reveal whether the result register is written when it should be held.

// File: rtl/andflag_pkg.sv
package andflag_pkg;
    localparam int DW = 64;
    localparam int IMMW = 32;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } size_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          wr_en;
        logic          sign;
        logic          zero;
        logic          parity;
        logic          carry;
        logic          ovf;
        logic          aux;
        logic          vld;
    } out_s;
endpackage

// File: rtl/andflag_mask.sv
module andflag_mask
    import andflag_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    sz,
    input  logic          imm,
    output logic [DW-1:0] prod,
    output logic          msb
);
    localparam int NW = 4;
    logic [DW-1:0] b_ext;
    logic [DW-1:0] raw;
    logic [NW-1:0][DW-1:0] masked;
    logic [NW-1:0] tops;

    always_comb begin
        b_ext = b;
        if (imm && sz == SZ_D)
            b_ext = {{(DW-IMMW){b[IMMW-1]}}, b[IMMW-1:0]};
        raw = a & b_ext;
    end

    for (genvar g = 0; g < NW; g++) begin : g_w
        localparam int W = 8 << g;
        assign masked[g] = {{(DW-W){1'b0}}, raw[W-1:0]};
        assign tops[g]   = raw[W-1];
    end

    assign prod = masked[sz];
    assign msb  = tops[sz];
endmodule

// File: rtl/andflag_flags.sv
module andflag_flags
    import andflag_pkg::*;
(
    input  logic [DW-1:0] prod,
    input  logic          msb,
    output logic          sign,
    output logic          zero,
    output logic          parity
);
    assign sign   = msb;
    assign zero   = (prod == '0);
    assign parity = ~(^prod[7:0]);
endmodule

// File: rtl/andflag_unit.sv
module andflag_unit
    import andflag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [63:0]   opa,
    input  logic [63:0]   opb,
    input  logic [1:0]    width_sel,
    input  logic          imm_mode,
    input  logic          cmp_mode,
    output logic [63:0]   res_q,
    output logic          wr_en_q,
    output logic          sign_q,
    output logic          zero_q,
    output logic          parity_q,
    output logic          carry_q,
    output logic          ovf_q,
    output logic          aux_q,
    output logic          flags_vld_q
);
    logic [DW-1:0] prod;
    logic msb, f_sign, f_zero, f_par;
    out_s st_d, st_q;

    andflag_mask u_mask (
        .a(opa), .b(opb), .sz(width_sel), .imm(imm_mode),
        .prod(prod), .msb(msb)
    );
    andflag_flags u_flags (
        .prod(prod), .msb(msb),
        .sign(f_sign), .zero(f_zero), .parity(f_par)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.vld   = 1'b0;
        if (in_valid) begin
            st_d.vld    = 1'b1;
            st_d.sign   = f_sign;
            st_d.zero   = f_zero;
            st_d.parity = f_par;
            st_d.carry  = 1'b0;
            st_d.ovf    = 1'b0;
            st_d.aux    = 1'b0;
            if (!cmp_mode) begin
                st_d.res   = prod;
                st_d.wr_en = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_q       = st_q.res;
    assign wr_en_q     = st_q.wr_en;
    assign sign_q      = st_q.sign;
    assign zero_q      = st_q.zero;
    assign parity_q    = st_q.parity;
    assign carry_q     = st_q.carry;
    assign ovf_q       = st_q.ovf;
    assign aux_q       = st_q.aux;
    assign flags_vld_q = st_q.vld;

    a_r6_fixed_flags_zero: assert property (@(posedge clk) disable iff (rst)
        !carry_q && !ovf_q && !aux_q);
    a_r7_wren_only_and: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cmp_mode) |=> wr_en_q);
    a_r7_no_wren_cmp: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && !cmp_mode) |=> !wr_en_q);
    a_r8_cmp_holds_res: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cmp_mode) |=> ($stable(res_q) && flags_vld_q));
    a_r9_vld_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> flags_vld_q);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!flags_vld_q && $stable(res_q) && $stable(zero_q)
                       && $stable(sign_q) && $stable(parity_q)));
    a_r4_zero_vs_res: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> (zero_q == (res_q == 64'd0)));
    a_r5_parity_vs_res: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> (parity_q == ~(^res_q[7:0])));
endmodule

// File: tb/test_andflag_unit.sv
module test_andflag_unit;
    localparam int CLK_PERIOD = 10;
    logic clk = 0, rst = 1, in_valid = 0, imm_mode = 0, cmp_mode = 0;
    logic [63:0] opa = 0, opb = 0;
    logic [1:0] width_sel = 0;
    logic [63:0] res_q;
    logic wr_en_q, sign_q, zero_q, parity_q, carry_q, ovf_q, aux_q, flags_vld_q;
    int checks = 0, fails = 0;
    logic [63:0] exp_res = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    andflag_unit i_andflag_unit (.*);

    function automatic logic [63:0] model(input logic [63:0] a, b,
                                          input logic [1:0] s, input logic im);
        logic [63:0] bb, r;
        bb = (im && s == 2'd3) ? {{32{b[31]}}, b[31:0]} : b;
        r = a & bb;
        case (s)
            2'd0: r = r & 64'hFF;
            2'd1: r = r & 64'hFFFF;
            2'd2: r = r & 64'hFFFF_FFFF;
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic top_bit(input logic [63:0] r, input logic [1:0] s);
        return r[(8 << s) - 1];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] a, b, input logic [1:0] s,
                       input logic im, cm);
        logic [63:0] r;
        r = model(a, b, s, im);
        @(negedge clk);
        opa = a; opb = b; width_sel = s; imm_mode = im; cmp_mode = cm; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        if (!cm) exp_res = r;
        chk("R1/R2/R8 res", res_q, exp_res);
        chk("R3 sign", {63'd0, sign_q}, {63'd0, top_bit(r, s)});
        chk("R4 zero", {63'd0, zero_q}, {63'd0, r == 0});
        chk("R5 parity", {63'd0, parity_q}, {63'd0, ~(^r[7:0])});
        chk("R6 cf/of/af", {61'd0, carry_q, ovf_q, aux_q}, 64'd0);
        chk("R7 wr_en", {63'd0, wr_en_q}, {63'd0, !cm});
        chk("R9 vld", {63'd0, flags_vld_q}, 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        chk("R10 reset res", res_q, 64'd0);
        chk("R10 reset flags", {56'd0, wr_en_q, sign_q, zero_q, parity_q,
                                carry_q, ovf_q, aux_q, flags_vld_q}, 64'd0);
        rst = 0;
        // R4: bits only above width -> zero
        run(64'hFFFF_FF00, 64'hFFFF_FF00, 2'd0, 0, 0);
        run(64'hFFFF_0000_0000_0000, 64'hFFFF_0000_0000_0000, 2'd2, 0, 0);
        // R5: low byte zero, upper set, full width
        run(64'h8000_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FF00, 2'd3, 0, 0);
        // R2: sign extension with bit 31 set and clear
        run(64'hFFFF_FFFF_0000_0001, 64'h0000_0000_8000_0001, 2'd3, 1, 0);
        run(64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_7000_0001, 2'd3, 1, 0);
        // R2: imm ignored at 32
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000, 2'd2, 1, 0);
        // R8: compare holds result
        run(64'h1234, 64'hFF00, 2'd1, 0, 1);
        run(64'h8000, 64'h8000, 2'd1, 0, 1);
        // R9: idle hold
        @(negedge clk);
        chk("R9 idle vld", {63'd0, flags_vld_q}, 64'd0);
        chk("R9 idle res", res_q, exp_res);
        for (int i = 0; i < 400; i++)
            run({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom),
                1'($urandom), 1'($urandom));
        @(negedge clk); rst = 1; @(negedge clk);
        chk("R10 reset again", res_q, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule